// File: doc/BRIEF.md
# Chunked Raster Video Timing Generator

This block produces the horizontal and vertical timing for a 50 Hz RGB raster. It runs on a master clock and receives a CPU-rate enable that is high on every second master clock. Each line is made of 40 equal chunks. Every chunk lasts 12 CPU clocks, which is 24 master clocks or 16 pixel periods, so one pixel period is one and a half master clocks. A frame is 312 lines long.

The block reports where the beam is. It gives the line number, the chunk number, the CPU-clock phase inside the chunk (used by a memory arbiter to place its access slots) and the pixel number inside the chunk. It also drives a pixel enable that is high on two master clocks out of every three. From the position it decodes a visible flag and a forced-black flag, an active-high vertical sync, and an active-low composite sync. Horizontal sync is placed by chunk number. The composite sync joins horizontal and vertical sync by XOR or by OR, as chosen by a parameter.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has line 0, chunk 0, CPU phase 0 and pixel index 0, and `pix_en` is high.
- R2: `cpu_phase` advances by one at each rising edge that samples `cpu_en` high. It counts 0 to 11 and wraps to 0 after 11.
- R3: `chunk_idx` advances at the edge where the phase wraps. It counts 0 to 39 and wraps to 0, and `line_idx` advances at that same edge. `line_idx` counts 0 to LINES-1 (default 311) and then wraps to 0.
- R4: `pix_en` follows the pattern high, high, low on master clocks, starting fresh at each chunk start. With `cpu_en` alternating, this gives 16 pixel enables per chunk.
- R5: `pix_idx` is 0 at each chunk start. It rises by one after each cycle in which `pix_en` is high, and it holds at 15.
- R6: `visible` is high exactly when chunk < 32 and line < VIS_LINES (default 256). `black` is always its complement.
- R7: Outside vertical sync, `csync_n` is low during chunks 34, 35 and 36 of every line and high elsewhere.
- R8: `vsync` is high for lines VS_START to VS_START+VS_LINES-1 (defaults 288 and 3) and low on all other lines.
- R9: During vertical sync, `csync_n` is the inverse of (hsync XOR vsync) in XOR mode, which is the default. In OR mode it is the inverse of (hsync OR vsync).
- R10: While `cpu_en` stays low, `cpu_phase`, `chunk_idx` and `line_idx` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_en | input | 1 | CPU-rate enable, high on every second master clock |
| pix_en | output | 1 | Pixel-rate enable (2 of every 3 master clocks) |
| pix_idx | output | 4 | Pixel number within the current chunk |
| cpu_phase | output | 4 | CPU-clock phase within the chunk, 0 to 11 |
| chunk_idx | output | 6 | Chunk number within the line, 0 to 39 |
| line_idx | output | 9 | Line number within the frame |
| visible | output | 1 | Beam is in the picture area |
| black | output | 1 | Output forced black |
| vsync | output | 1 | Vertical sync, active high |
| csync_n | output | 1 | Composite sync, active low |

## Verification
Any fault in the phase counter moves every chunk boundary after it. Within 12 CPU clocks, a wrong `chunk_idx` or a misplaced sync pulse then shows at the ports. A pixel divider that is out of step shows inside the same chunk: `pix_idx` is not at 15 at the chunk end, or the enable pattern has two low cycles in a row. A wrong line count shows up on `visible` and `vsync` the moment the line boundary passes. The bench samples points chosen at each of these boundaries and compares them against position values worked out from the elapsed master-clock count.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic {
        CSYNC_OR  = 1'b0,
        CSYNC_XOR = 1'b1
    } csync_mode_e;

    function automatic int unsigned width_of(input int unsigned count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/rt_horiz.sv
module rt_horiz #(
    parameter int unsigned CPU_PER_CHUNK = 12,
    parameter int unsigned CHUNKS        = 40,
    localparam int unsigned MASTER_PER_CHUNK = 2 * CPU_PER_CHUNK,
    localparam int unsigned PIX_PER_CHUNK    = (MASTER_PER_CHUNK * 2) / 3,
    localparam int unsigned PH_W    = raster_pkg::width_of(CPU_PER_CHUNK),
    localparam int unsigned CHUNK_W = raster_pkg::width_of(CHUNKS),
    localparam int unsigned PIX_W   = raster_pkg::width_of(PIX_PER_CHUNK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_en,
    output logic               pix_en,
    output logic [PIX_W-1:0]   pix_idx,
    output logic [PH_W-1:0]    cpu_phase,
    output logic [CHUNK_W-1:0] chunk_idx,
    output logic               line_adv
);
    localparam logic [PH_W-1:0]    PH_LAST    = PH_W'(CPU_PER_CHUNK - 1);
    localparam logic [CHUNK_W-1:0] CHUNK_LAST = CHUNK_W'(CHUNKS - 1);
    localparam logic [PIX_W-1:0]   PIX_LAST   = PIX_W'(PIX_PER_CHUNK - 1);

    typedef struct packed {
        logic [PH_W-1:0]    phase;
        logic [CHUNK_W-1:0] chunk;
        logic [1:0]         pdiv;
        logic [PIX_W-1:0]   pix;
    } hstate_t;

    hstate_t st_d, st_q;
    logic    chunk_end_d;
    logic    line_end_d;

    always_comb begin
        st_d        = st_q;
        chunk_end_d = cpu_en && (st_q.phase == PH_LAST);
        line_end_d  = chunk_end_d && (st_q.chunk == CHUNK_LAST);
        if (cpu_en) begin
            st_d.phase = chunk_end_d ? '0 : st_q.phase + 1'b1;
        end
        if (chunk_end_d) begin
            st_d.chunk = line_end_d ? '0 : st_q.chunk + 1'b1;
            st_d.pdiv  = 2'd0;
            st_d.pix   = '0;
        end else begin
            st_d.pdiv = (st_q.pdiv == 2'd2) ? 2'd0 : st_q.pdiv + 2'd1;
            if ((st_q.pdiv != 2'd2) && (st_q.pix != PIX_LAST)) begin
                st_d.pix = st_q.pix + 1'b1;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pix_en    = (st_q.pdiv != 2'd2);
    assign pix_idx   = st_q.pix;
    assign cpu_phase = st_q.phase;
    assign chunk_idx = st_q.chunk;
    assign line_adv  = line_end_d;

    // R2: the phase only moves on a sampled CPU enable
    a_r2_phase_on_enable: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.phase) |-> $past(cpu_en));

    // R3: a chunk step only follows the last CPU phase
    a_r3_chunk_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.chunk) |-> ($past(cpu_en) && ($past(st_q.phase) == PH_LAST)));

    // R4: the pixel enable never has two idle master clocks in a row
    a_r4_no_double_gap: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> pix_en);

    // R5: each new chunk starts at pixel 0
    a_r5_pix_restart: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.chunk) |-> (st_q.pix == '0));

endmodule

// File: rtl/rt_vert.sv
module rt_vert #(
    parameter int unsigned LINES = 312,
    localparam int unsigned LINE_W = raster_pkg::width_of(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_adv,
    output logic [LINE_W-1:0] line_idx
);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } vstate_t;

    vstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_adv) begin
            st_d.line = (st_q.line == LINE_LAST) ? '0 : st_q.line + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign line_idx = st_q.line;

    // R3: the line number only moves at the end of the last chunk
    a_r3_line_on_adv: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.line) |-> $past(line_adv));

    // R3: the line number stays inside the frame
    a_r3_line_range: assert property (@(posedge clk) disable iff (rst)
        st_q.line <= LINE_LAST);

endmodule

// File: rtl/rt_decode.sv
module rt_decode import raster_pkg::*; #(
    parameter int unsigned CHUNKS     = 40,
    parameter int unsigned VIS_CHUNKS = 32,
    parameter int unsigned HS_FIRST   = 34,
    parameter int unsigned HS_LEN     = 3,
    parameter int unsigned LINES      = 312,
    parameter int unsigned VIS_LINES  = 256,
    parameter int unsigned VS_START   = 288,
    parameter int unsigned VS_LINES   = 3,
    parameter csync_mode_e CSYNC_MODE = CSYNC_XOR,
    localparam int unsigned CHUNK_W = width_of(CHUNKS),
    localparam int unsigned LINE_W  = width_of(LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CHUNK_W-1:0] chunk_idx,
    input  logic [LINE_W-1:0]  line_idx,
    output logic               visible,
    output logic               black,
    output logic               vsync,
    output logic               csync_n
);
    localparam logic [CHUNK_W-1:0] VIS_CHUNK_END = CHUNK_W'(VIS_CHUNKS);
    localparam logic [CHUNK_W-1:0] HS_BEGIN      = CHUNK_W'(HS_FIRST);
    localparam logic [CHUNK_W-1:0] HS_END        = CHUNK_W'(HS_FIRST + HS_LEN);
    localparam logic [LINE_W-1:0]  VIS_LINE_END  = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0]  VS_BEGIN      = LINE_W'(VS_START);
    localparam logic [LINE_W-1:0]  VS_END        = LINE_W'(VS_START + VS_LINES);

    logic hsync;

    assign visible = (chunk_idx < VIS_CHUNK_END) && (line_idx < VIS_LINE_END);
    assign black   = !visible;
    assign hsync   = (chunk_idx >= HS_BEGIN) && (chunk_idx < HS_END);
    assign vsync   = (line_idx >= VS_BEGIN) && (line_idx < VS_END);

    generate
        if (CSYNC_MODE == CSYNC_XOR) begin : g_csync_xor
            assign csync_n = !(hsync ^ vsync);
        end else begin : g_csync_or
            assign csync_n = !(hsync || vsync);
        end
    endgenerate

    // R7 and R8: sync intervals fall inside the blanked region
    a_r7_sync_in_blank: assert property (@(posedge clk) disable iff (rst)
        (hsync || vsync) |-> black);

    // R9: away from both sync pulses the composite sync is idle
    a_r9_csync_idle: assert property (@(posedge clk) disable iff (rst)
        (!hsync && !vsync) |-> csync_n);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import raster_pkg::*; #(
    parameter int unsigned CPU_PER_CHUNK = 12,
    parameter int unsigned CHUNKS        = 40,
    parameter int unsigned VIS_CHUNKS    = 32,
    parameter int unsigned HS_FIRST      = 34,
    parameter int unsigned HS_LEN        = 3,
    parameter int unsigned LINES         = 312,
    parameter int unsigned VIS_LINES     = 256,
    parameter int unsigned VS_START      = 288,
    parameter int unsigned VS_LINES      = 3,
    parameter csync_mode_e CSYNC_MODE    = CSYNC_XOR,
    localparam int unsigned PIX_PER_CHUNK = (4 * CPU_PER_CHUNK) / 3,
    localparam int unsigned PH_W    = width_of(CPU_PER_CHUNK),
    localparam int unsigned CHUNK_W = width_of(CHUNKS),
    localparam int unsigned PIX_W   = width_of(PIX_PER_CHUNK),
    localparam int unsigned LINE_W  = width_of(LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_en,
    output logic               pix_en,
    output logic [PIX_W-1:0]   pix_idx,
    output logic [PH_W-1:0]    cpu_phase,
    output logic [CHUNK_W-1:0] chunk_idx,
    output logic [LINE_W-1:0]  line_idx,
    output logic               visible,
    output logic               black,
    output logic               vsync,
    output logic               csync_n
);
    logic line_adv;

    rt_horiz #(
        .CPU_PER_CHUNK(CPU_PER_CHUNK),
        .CHUNKS       (CHUNKS)
    ) i_horiz (
        .clk      (clk),
        .rst      (rst),
        .cpu_en   (cpu_en),
        .pix_en   (pix_en),
        .pix_idx  (pix_idx),
        .cpu_phase(cpu_phase),
        .chunk_idx(chunk_idx),
        .line_adv (line_adv)
    );

    rt_vert #(
        .LINES(LINES)
    ) i_vert (
        .clk     (clk),
        .rst     (rst),
        .line_adv(line_adv),
        .line_idx(line_idx)
    );

    rt_decode #(
        .CHUNKS    (CHUNKS),
        .VIS_CHUNKS(VIS_CHUNKS),
        .HS_FIRST  (HS_FIRST),
        .HS_LEN    (HS_LEN),
        .LINES     (LINES),
        .VIS_LINES (VIS_LINES),
        .VS_START  (VS_START),
        .VS_LINES  (VS_LINES),
        .CSYNC_MODE(CSYNC_MODE)
    ) i_decode (
        .clk      (clk),
        .rst      (rst),
        .chunk_idx(chunk_idx),
        .line_idx (line_idx),
        .visible  (visible),
        .black    (black),
        .vsync    (vsync),
        .csync_n  (csync_n)
    );

    // R10: with no CPU enable the chunk position holds
    a_r10_hold_chunk: assert property (@(posedge clk) disable iff (rst)
        !cpu_en |=> $stable(chunk_idx));

    // R6: line position and visibility agree after the last picture line
    a_r6_blank_lines: assert property (@(posedge clk) disable iff (rst)
        (line_idx >= LINE_W'(VIS_LINES)) |-> black);

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
    import raster_pkg::*;

    localparam int unsigned T_LINES = 24;
    localparam int unsigned T_VIS   = 16;
    localparam int unsigned T_VS0   = 18;
    localparam int unsigned T_VSN   = 3;
    localparam int unsigned NSAMP   = 26;
    localparam int unsigned SAMPLES [NSAMP] = '{
        0, 1, 2, 3, 22, 23, 24, 25, 749, 768, 815, 816, 874, 888, 959, 960,
        15100, 15365, 17380, 18120, 20016, 20976, 23039, 23040, 23041, 23859
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_en = 1'b0;
    always #2.5 clk = ~clk;

    logic       pen_x, vis_x, blk_x, vs_x, cs_x;
    logic [3:0] pix_x, ph_x;
    logic [5:0] ch_x;
    logic [4:0] ln_x;
    logic       pen_o, vis_o, blk_o, vs_o, cs_o;
    logic [3:0] pix_o, ph_o;
    logic [5:0] ch_o;
    logic [4:0] ln_o;

    raster_timing_gen #(
        .LINES(T_LINES), .VIS_LINES(T_VIS), .VS_START(T_VS0), .VS_LINES(T_VSN),
        .CSYNC_MODE(CSYNC_XOR)
    ) i_raster_timing_gen (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .pix_en(pen_x), .pix_idx(pix_x),
        .cpu_phase(ph_x), .chunk_idx(ch_x), .line_idx(ln_x), .visible(vis_x),
        .black(blk_x), .vsync(vs_x), .csync_n(cs_x)
    );

    raster_timing_gen #(
        .LINES(T_LINES), .VIS_LINES(T_VIS), .VS_START(T_VS0), .VS_LINES(T_VSN),
        .CSYNC_MODE(CSYNC_OR)
    ) i_raster_timing_gen_or (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .pix_en(pen_o), .pix_idx(pix_o),
        .cpu_phase(ph_o), .chunk_idx(ch_o), .line_idx(ln_o), .visible(vis_o),
        .black(blk_o), .vsync(vs_o), .csync_n(cs_o)
    );

    int total = 0;
    int bad = 0;
    int k = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at step %0d", tag, act, exp, k);
        end
    endtask

    task automatic step();
        @(posedge clk);
        k++;
        @(negedge clk);
        cpu_en = (k % 2 == 1);
    endtask

    task automatic check_at(input int n);
        int m, pdiv, e_ph, e_ch, e_ln, e_pix, e_pen, e_vis, e_hs, e_vs;
        m     = n % 24;
        pdiv  = m % 3;
        e_ph  = (n / 2) % 12;
        e_ch  = (n / 24) % 40;
        e_ln  = (n / 960) % T_LINES;
        e_pen = (pdiv != 2) ? 1 : 0;
        e_pix = (m / 3) * 2 + pdiv;
        if (e_pix > 15) e_pix = 15;
        e_vis = (e_ch < 32 && e_ln < T_VIS) ? 1 : 0;
        e_hs  = (e_ch >= 34 && e_ch <= 36) ? 1 : 0;
        e_vs  = (e_ln >= T_VS0 && e_ln < T_VS0 + T_VSN) ? 1 : 0;
        chk("R2 cpu_phase", int'(ph_x), e_ph);
        chk("R3 chunk_idx", int'(ch_x), e_ch);
        chk("R3 line_idx", int'(ln_x), e_ln);
        chk("R4 pix_en", int'(pen_x), e_pen);
        chk("R5 pix_idx", int'(pix_x), e_pix);
        chk("R6 visible", int'(vis_x), e_vis);
        chk("R6 black", int'(blk_x), 1 - e_vis);
        chk("R8 vsync", int'(vs_x), e_vs);
        if (e_vs == 0) begin
            chk("R7 csync_n", int'(cs_x), (e_hs == 1) ? 0 : 1);
        end else begin
            chk("R9 csync_n xor", int'(cs_x), (e_hs ^ e_vs) ? 0 : 1);
        end
        chk("R9 csync_n or", int'(cs_o), (e_hs | e_vs) ? 0 : 1);
        chk("R3 chunk_idx or-mode", int'(ch_o), e_ch);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cpu_en = 1'b0;
        k = 0;
        // R1: state right after reset
        chk("R1 line_idx", int'(ln_x), 0);
        chk("R1 pix_en", int'(pen_x), 1);
        for (int i = 0; i < int'(NSAMP); i++) begin
            while (k < int'(SAMPLES[i])) step();
            check_at(k);
        end
        // R10: stall the CPU enable and look for held counters
        begin
            int h_ph, h_ch, h_ln;
            h_ph = int'(ph_x); h_ch = int'(ch_x); h_ln = int'(ln_x);
            cpu_en = 1'b0;
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk("R10 cpu_phase hold", int'(ph_x), h_ph);
            chk("R10 chunk_idx hold", int'(ch_x), h_ch);
            chk("R10 line_idx hold", int'(ln_x), h_ln);
        end
        // R1: reset in the middle of a frame
        cpu_en = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 cpu_phase", int'(ph_x), 0);
        chk("R1 chunk_idx", int'(ch_x), 0);
        chk("R1 line_idx", int'(ln_x), 0);
        chk("R1 pix_idx", int'(pix_x), 0);
        chk("R1 pix_en", int'(pen_x), 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule